// File: doc/BRIEF.md
# Overlap-Safe Rectangle Copy Engine

This block moves a rectangle of 8-bit pixels from one place in a frame buffer to another place in the same buffer. Software writes the source corner, the rectangle size, a plane mask and a raster-operation code over a small register port. A write to the destination register starts the copy. The engine then walks the rectangle. For each pixel it reads the source, reads the destination and writes back the raster-op result, making one access per cycle on a synchronous single-port pixel memory.

The engine picks the row order and the column order from where the destination sits relative to the source. Because of this, a copy whose source and destination overlap reads every source pixel before that pixel is overwritten. The size is clamped to the buffer dimensions. A pixel whose linear address falls outside the buffer is skipped. A nonzero control-plane register blocks any new copy.

The memory port has no back-pressure. The memory must accept a request in every cycle in which `mem_req` is high. Read data must appear on `mem_rdata` in the cycle after the read request.

Top module: `rect_copy_engine`

## Requirements
- R1: Register map on `reg_addr`:
  - 0 is the source corner.
  - 1 is the size.
  - 2 is the plane mask (bits 7:0 are used).
  - 3 is the raster-op code (bits 3:0 are used).
  - 4 is control-plane.
  - 5 is the destination, and a write to 5 starts the copy.
  - Coordinates and sizes pack X in bits 31:16 and Y in bits 15:0.
- R2: When destination Y > source Y, rows are processed from the last row to the first. Otherwise they are processed from the first row to the last. Overlapping vertical copies therefore produce a faithful copy of the original source.
- R3: When destination X > source X, columns are processed from right to left. Otherwise they are processed from left to right.
- R4: Before the walk starts, width is clamped to BUF_W and height is clamped to BUF_H. A zero width or zero height copies nothing.
- R5: A pixel whose source or destination linear address is at or above BUF_W*BUF_H is skipped without any memory access, and the walk continues with the next pixel.
- R6: Raster-op codes:
  - 0 clears the masked bits.
  - 3 replaces the masked bits with the source.
  - 6 XORs the source into the masked bits.
  - 10 inverts the masked destination bits.
  - 15 sets the masked bits.
  - Any other code writes the destination back unchanged.
- R7: Destination bits outside the plane mask are never changed.
- R8: While the control-plane register is nonzero, a destination write is ignored. No busy cycle, no memory access and no done pulse follow it.
- R9: A destination write that arrives while busy is ignored. The running copy completes unaltered and gives exactly one done pulse.
- R10: `busy` rises in the cycle after the triggering write. It then stays high for 1 setup cycle plus 3 cycles per copied pixel plus 1 cycle per skipped pixel. `done` is high for exactly one cycle right after that, and `busy` is low during it.
- R11: The linear address is y*BUF_W + x, where y and x are the source or destination coordinate plus the row or column offset. Each copied pixel performs exactly one read of the source, then one read of the destination, then one write to the destination address.
- R12: After reset:
  - `busy`, `done` and `mem_req` are low.
  - The plane mask is 0xFF.
  - The raster-op code is 3.
  - All other registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Pixel memory access request |
| mem_we | output | 1 | Access is a write (1) or a read (0) |
| mem_addr | output | $clog2(BUF_W*BUF_H) | Linear pixel address |
| mem_wdata | output | 8 | Pixel write data |
| mem_rdata | input | 8 | Pixel read data, valid the cycle after a read request |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse when a copy finishes |

## Verification
The copy is exercised with four kinds of overlapping rectangle:
- Shifted down-right and shifted up-left pairs show that rows and columns are walked in the safe order. A wrong direction smears repeated pixels across the destination.
- Shifted down-left and shifted up-right pairs separate the row decision from the column decision.

Oversized, zero-sized and partly out-of-buffer rectangles distinguish clamping from skipping. Here the count of busy cycles and memory accesses shows whether a skipped pixel still touched memory.

Each raster-op code, including an undefined one, is tried under full, partial and empty plane masks. This shows that only masked bits move.

Random rectangles with random codes and masks are compared against a bench model that walks in the same order.

// File: rtl/rce_pkg.sv
package rce_pkg;

  localparam logic [2:0] REG_SRC   = 3'd0;
  localparam logic [2:0] REG_SIZE  = 3'd1;
  localparam logic [2:0] REG_PMASK = 3'd2;
  localparam logic [2:0] REG_ROP   = 3'd3;
  localparam logic [2:0] REG_CTRL  = 3'd4;
  localparam logic [2:0] REG_DST   = 3'd5;

  localparam logic [3:0] ROP_CLEAR = 4'd0;
  localparam logic [3:0] ROP_COPY  = 4'd3;
  localparam logic [3:0] ROP_XOR   = 4'd6;
  localparam logic [3:0] ROP_INV   = 4'd10;
  localparam logic [3:0] ROP_SET   = 4'd15;

  typedef struct packed {
    logic [15:0] x;
    logic [15:0] y;
  } xy_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RSRC,
    ST_RDST,
    ST_WR,
    ST_DONE
  } state_e;

endpackage

// File: rtl/rce_regs.sv
module rce_regs
  import rce_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  input  logic        busy,
  output xy_t         src,
  output xy_t         size,
  output xy_t         dst,
  output logic [7:0]  pmask,
  output logic [3:0]  rop,
  output logic        start
);

  logic [31:0] ctrl_q;

  // R8, R9: a trigger counts only when idle and the control plane is clear
  assign start = wr && (addr == REG_DST) && !busy && (ctrl_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src    <= '0;
      size   <= '0;
      dst    <= '0;
      pmask  <= 8'hFF;
      rop    <= ROP_COPY;
      ctrl_q <= '0;
    end else if (wr) begin
      case (addr)
        REG_SRC:   src    <= wdata;
        REG_SIZE:  size   <= wdata;
        REG_PMASK: pmask  <= wdata[7:0];
        REG_ROP:   rop    <= wdata[3:0];
        REG_CTRL:  ctrl_q <= wdata;
        REG_DST:   if (start) dst <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rce_walker.sv
module rce_walker #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [CW-1:0] w,
  input  logic [CW-1:0] h,
  input  logic          row_rev,
  input  logic          col_rev,
  output logic [CW-1:0] row_off,
  output logic [CW-1:0] col_off,
  output logic          last
);

  logic [CW-1:0] i_q, j_q, wl_q, hl_q;
  logic          rr_q, cr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_q  <= '0;
      j_q  <= '0;
      wl_q <= '0;
      hl_q <= '0;
      rr_q <= 1'b0;
      cr_q <= 1'b0;
    end else if (load) begin
      i_q  <= '0;
      j_q  <= '0;
      wl_q <= w;
      hl_q <= h;
      rr_q <= row_rev;
      cr_q <= col_rev;
    end else if (step) begin
      if (j_q == wl_q - 1'b1) begin
        j_q <= '0;
        i_q <= i_q + 1'b1;
      end else begin
        j_q <= j_q + 1'b1;
      end
    end
  end

  // R2, R3: the reversal flags mirror the offsets within the rectangle
  assign row_off = rr_q ? (hl_q - 1'b1 - i_q) : i_q;
  assign col_off = cr_q ? (wl_q - 1'b1 - j_q) : j_q;
  assign last    = (i_q == hl_q - 1'b1) && (j_q == wl_q - 1'b1);

  a_r4_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (i_q < hl_q) && (j_q < wl_q));

endmodule

// File: rtl/rce_rop.sv
module rce_rop
  import rce_pkg::*;
(
  input  logic [3:0] op,
  input  logic [7:0] mask,
  input  logic [7:0] src_pix,
  input  logic [7:0] dst_pix,
  output logic [7:0] res
);

  always_comb begin
    case (op)
      ROP_CLEAR: res = dst_pix & ~mask;
      ROP_COPY:  res = (dst_pix & ~mask) | (src_pix & mask);
      ROP_XOR:   res = dst_pix ^ (src_pix & mask);
      ROP_INV:   res = dst_pix ^ mask;
      ROP_SET:   res = dst_pix | mask;
      default:   res = dst_pix;
    endcase
  end

  // R7: unmasked destination bits pass through untouched
  always_comb begin
    a_r7_unmasked_hold: assert (((res ^ dst_pix) & ~mask) == 8'h00);
  end

endmodule

// File: rtl/rect_copy_engine.sv
module rect_copy_engine
  import rce_pkg::*;
#(
  parameter int  BUF_W    = 64,
  parameter int  BUF_H    = 32,
  localparam int BUF_SIZE = BUF_W * BUF_H,
  localparam int MA_W     = $clog2(BUF_SIZE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [MA_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic            busy,
  output logic            done
);

  localparam int CW    = 16;
  localparam int LIN_W = 18 + $clog2(BUF_W);

  xy_t        src_r, size_r, dst_r;
  logic [7:0] pmask_r;
  logic [3:0] rop_r;
  logic       start;

  state_e     st;
  xy_t        src_q;
  logic [7:0] mask_q, src_pix;
  logic [3:0] op_q;

  logic [CW-1:0]    w_cl, h_cl, row_off, col_off;
  logic             last, load, step, skip;
  logic [LIN_W-1:0] src_lin, dst_lin;

  rce_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .busy  (busy),
    .src   (src_r),
    .size  (size_r),
    .dst   (dst_r),
    .pmask (pmask_r),
    .rop   (rop_r),
    .start (start)
  );

  // R4: clamp to the buffer dimensions
  assign w_cl = (size_r.x > CW'(BUF_W)) ? CW'(BUF_W) : size_r.x;
  assign h_cl = (size_r.y > CW'(BUF_H)) ? CW'(BUF_H) : size_r.y;

  assign load = (st == ST_SETUP);
  assign step = (st == ST_WR) || ((st == ST_RSRC) && skip);

  rce_walker #(.CW(CW)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .w       (w_cl),
    .h       (h_cl),
    .row_rev (dst_r.y > src_r.y),
    .col_rev (dst_r.x > src_r.x),
    .row_off (row_off),
    .col_off (col_off),
    .last    (last)
  );

  // R11: linear address from row and column
  function automatic logic [LIN_W-1:0] lin_of(logic [15:0] bx, logic [15:0] by,
                                               logic [CW-1:0] ox, logic [CW-1:0] oy);
    logic [16:0] px, py;
    px = {1'b0, bx} + {1'b0, ox};
    py = {1'b0, by} + {1'b0, oy};
    return LIN_W'(py) * LIN_W'(BUF_W) + LIN_W'(px);
  endfunction

  assign src_lin = lin_of(src_q.x, src_q.y, col_off, row_off);
  assign dst_lin = lin_of(dst_r.x, dst_r.y, col_off, row_off);
  assign skip    = (src_lin >= LIN_W'(BUF_SIZE)) || (dst_lin >= LIN_W'(BUF_SIZE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      src_q   <= '0;
      mask_q  <= '0;
      op_q    <= '0;
      src_pix <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: st <= start ? ST_SETUP : ST_IDLE;
        ST_SETUP: begin
          src_q  <= src_r;
          mask_q <= pmask_r;
          op_q   <= rop_r;
          st     <= ((w_cl == '0) || (h_cl == '0)) ? ST_DONE : ST_RSRC;
        end
        ST_RSRC: begin
          if (skip) st <= last ? ST_DONE : ST_RSRC;
          else      st <= ST_RDST;
        end
        ST_RDST: begin
          src_pix <= mem_rdata;
          st      <= ST_WR;
        end
        ST_WR:   st <= last ? ST_DONE : ST_RSRC;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req  = ((st == ST_RSRC) && !skip) || (st == ST_RDST) || (st == ST_WR);
  assign mem_we   = (st == ST_WR);
  assign mem_addr = MA_W'((st == ST_RSRC) ? src_lin : dst_lin);
  assign busy     = (st == ST_SETUP) || (st == ST_RSRC) || (st == ST_RDST) || (st == ST_WR);
  assign done     = (st == ST_DONE);

  rce_rop u_rop (
    .op      (op_q),
    .mask    (mask_q),
    .src_pix (src_pix),
    .dst_pix (mem_rdata),
    .res     (mem_wdata)
  );

  a_r11_write_after_dst_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($past(mem_req) && !$past(mem_we) && ($past(mem_addr) == mem_addr)));

  a_r10_busy_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_no_access_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

endmodule

// File: tb/rect_copy_engine_tb.sv
module rect_copy_engine_tb;

  localparam int BW  = 64;
  localparam int BH  = 32;
  localparam int SZ  = BW * BH;
  localparam int MAW = $clog2(SZ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            reg_wr = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic            mem_req, mem_we, busy, done;
  logic [MAW-1:0]  mem_addr;
  logic [7:0]      mem_wdata;
  logic [7:0]      mem_rdata;

  rect_copy_engine #(.BUF_W(BW), .BUF_H(BH)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .done      (done)
  );

  function automatic logic [7:0] init_val(int k);
    return 8'((k * 73) ^ (k >> 3));
  endfunction

  logic [7:0] mem [SZ];
  logic [7:0] ref_mem [SZ];
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SZ; k++) mem[k] <= init_val(k);
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_req) begin
      if (mem_we) wr_cnt <= wr_cnt + 1;
      else        rd_cnt <= rd_cnt + 1;
    end
    if (rst_n && done) done_cnt <= done_cnt + 1;
  end

  int n_chk = 0, n_fail = 0;
  int exp_p, exp_s;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_rop(int op, logic [7:0] m, logic [7:0] s, logic [7:0] d);
    case (op)
      0:  return d & ~m;
      3:  return (d & ~m) | (s & m);
      6:  return d ^ (s & m);
      10: return d ^ m;
      15: return d | m;
      default: return d;
    endcase
  endfunction

  task automatic ref_copy(int sx, int sy, int dx, int dy, int w, int h, int op, logic [7:0] m);
    bit down, right;
    exp_p = 0;
    exp_s = 0;
    if (w > BW) w = BW;
    if (h > BH) h = BH;
    down  = dy > sy;
    right = dx > sx;
    for (int li = 0; li < h; li++) begin
      for (int lj = 0; lj < w; lj++) begin
        int r, c, sa, da;
        r  = down  ? h - 1 - li : li;
        c  = right ? w - 1 - lj : lj;
        sa = (sy + r) * BW + sx + c;
        da = (dy + r) * BW + dx + c;
        if (sa >= SZ || da >= SZ) exp_s++;
        else begin
          ref_mem[da] = ref_rop(op, m, ref_mem[sa], ref_mem[da]);
          exp_p++;
        end
      end
    end
  endtask

  task automatic compare_mem(string req);
    int bad = 0, first = -1;
    for (int k = 0; k < SZ; k++) begin
      if (mem[k] !== ref_mem[k]) begin
        bad++;
        if (first < 0) first = k;
      end
    end
    if (first < 0) chk(1'b1, req, "pixels", 0, 0);
    else chk(1'b0, req, $sformatf("pixel %0d", first), int'(mem[first]), int'(ref_mem[first]));
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  // waits at negedges from the cycle after the trigger; returns busy count
  task automatic wait_done(string req, output int bc);
    int t = 0;
    bc = 0;
    while (!done && t < 5000) begin
      if (busy) bc++;
      t++;
      @(negedge clk);
    end
    chk(t < 5000, req, "done reached", t, 0);
    chk(!busy, "R10", "busy during done", int'(busy), 0);
    @(negedge clk);
  endtask

  task automatic run_copy(string req, int sx, int sy, int dx, int dy, int w, int h,
                          int op, logic [7:0] m, bit wr_mode);
    int r0, w0, d0, bc;
    if (wr_mode) begin
      reg_write(3'd3, 32'(op));
      reg_write(3'd2, {24'h0, m});
    end
    reg_write(3'd0, {16'(sx), 16'(sy)});
    reg_write(3'd1, {16'(w), 16'(h)});
    ref_copy(sx, sy, dx, dy, w, h, op, m);
    r0 = rd_cnt; w0 = wr_cnt; d0 = done_cnt;
    reg_write(3'd5, {16'(dx), 16'(dy)});
    chk(busy, "R10", "busy after trigger", int'(busy), 1);
    wait_done(req, bc);
    compare_mem(req);
    chk(rd_cnt - r0 == 2 * exp_p, "R11", "reads", rd_cnt - r0, 2 * exp_p);
    chk(wr_cnt - w0 == exp_p, "R11", "writes", wr_cnt - w0, exp_p);
    chk(bc == 1 + 3 * exp_p + exp_s, "R10", "busy cycles", bc, 1 + 3 * exp_p + exp_s);
    chk(done_cnt - d0 == 1, "R10", "done pulses", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    int ops[6] = '{0, 3, 6, 10, 15, 7};
    void'($urandom(32'd2024));
    for (int k = 0; k < SZ; k++) ref_mem[k] = init_val(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(!busy && !done && !mem_req, "R12", "idle outputs", int'({busy, done, mem_req}), 0);

    // R12 + R1: defaults (mask FF, copy) without writing op/mask
    run_copy("R12", 2, 2, 20, 3, 5, 4, 3, 8'hFF, 1'b0);
    // R2 / R3 overlap in all four directions
    run_copy("R2", 10, 5, 12, 7, 8, 6, 3, 8'hFF, 1'b1);
    run_copy("R3", 12, 9, 10, 8, 8, 6, 3, 8'hFF, 1'b1);
    run_copy("R2", 30, 5, 28, 8, 7, 5, 3, 8'hFF, 1'b1);
    run_copy("R3", 30, 12, 33, 10, 7, 5, 3, 8'hFF, 1'b1);
    // R4 clamp width and height; zero size
    run_copy("R4", 0, 0, 0, 20, 300, 2, 3, 8'hFF, 1'b1);
    run_copy("R4", 40, 0, 41, 0, 3, 500, 3, 8'hFF, 1'b1);
    run_copy("R4", 5, 5, 9, 9, 0, 4, 3, 8'hFF, 1'b1);
    // R5 skip out of range source and destination
    run_copy("R5", 5, 28, 5, 2, 4, 8, 3, 8'hFF, 1'b1);
    run_copy("R5", 0, 0, 62, 30, 4, 4, 3, 8'hFF, 1'b1);
    // R6 every code, R7 masks
    foreach (ops[q]) run_copy("R6", 1, 20, 40, 22, 6, 3, ops[q], 8'hFF, 1'b1);
    run_copy("R7", 3, 10, 20, 14, 6, 3, 6, 8'h0F, 1'b1);
    run_copy("R7", 3, 10, 20, 14, 6, 3, 15, 8'h00, 1'b1);
    run_copy("R7", 3, 10, 20, 14, 6, 3, 10, 8'hA5, 1'b1);

    // R8: control plane blocks trigger
    begin
      int w0, d0, bsum;
      reg_write(3'd4, 32'h1);
      w0 = wr_cnt; d0 = done_cnt; bsum = 0;
      reg_write(3'd5, {16'd50, 16'd1});
      repeat (20) begin
        if (busy) bsum++;
        @(negedge clk);
      end
      chk(bsum == 0, "R8", "busy cycles", bsum, 0);
      chk(wr_cnt == w0 && done_cnt == d0, "R8", "writes+done", wr_cnt - w0 + done_cnt - d0, 0);
      compare_mem("R8");
      reg_write(3'd4, 32'h0);
    end

    // R9: second trigger during busy is ignored
    begin
      int d0, bc;
      reg_write(3'd3, 32'd3);
      reg_write(3'd2, 32'hFF);
      reg_write(3'd0, {16'd0, 16'd0});
      reg_write(3'd1, {16'd6, 16'd4});
      ref_copy(0, 0, 50, 10, 6, 4, 3, 8'hFF);
      d0 = done_cnt;
      reg_write(3'd5, {16'd50, 16'd10});
      reg_write(3'd5, {16'd20, 16'd25});
      wait_done("R9", bc);
      repeat (5) @(negedge clk);
      compare_mem("R9");
      chk(done_cnt - d0 == 1, "R9", "done pulses", done_cnt - d0, 1);
    end

    // random copies, R2 R3 R5 R6 mixed
    for (int n = 0; n < 40; n++) begin
      int sx, sy, dx, dy, w, h, op;
      sx = $urandom_range(0, 60);
      sy = $urandom_range(0, 34);
      if ($urandom_range(0, 1) == 1) begin
        dx = sx + $urandom_range(0, 8) - 4;
        dy = sy + $urandom_range(0, 8) - 4;
        if (dx < 0) dx = 0;
        if (dy < 0) dy = 0;
      end else begin
        dx = $urandom_range(0, 63);
        dy = $urandom_range(0, 33);
      end
      w  = $urandom_range(0, 20);
      h  = $urandom_range(0, 12);
      op = ops[$urandom_range(0, 5)];
      run_copy("R6", sx, sy, dx, dy, w, h, op, 8'($urandom()), 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule